// File: doc/BRIEF.md
# Carrier Configuration Registers and Mezzanine TDM Line Router

This block holds the configuration and identity registers of a two-slot mezzanine carrier. The registers sit on a byte-wide local bus. Software uses them to read the three 5-bit geographic address codes presented by the backplane. It also uses them to set the upper bus-mode lines of both mezzanines, to pick the termination for the two clock/frame groups, to give each slot its slot ID, and to read two fixed revision codes. Only the low four address bits are decoded, so the 16-byte window repeats across the rest of the address space. All pin inputs reach the registers through a two-flop synchronizer.

The block also contains the data-line switch between the 32-line TDM buses of the two mezzanines and the 32-line local bus of the time-slot switch device. Every line is modelled as an open-drain wire. Each party drives an active-low pull vector (0 pulls the line low, 1 releases it), and each party sees the AND of everything joined to its line. One control bit selects the mode. In legacy mode each mezzanine has a private 16-line half of the switch bus. In shared mode all three buses form one 32-line bus.

The slot-ID byte takes part of its reset value from the live primary geographic address. It is loaded once the synchronizer holds that address.

Top module: `carrier_cfg_router`

## Requirements
- R1: While reset is asserted, the control byte (offset 0x7) reads 0x73 when both mezzanine bus-mode line 1 inputs are low. Routing select is 0, the three bus-mode outputs are 1, and both termination enables are 1.
- R2: Offsets 0x4, 0x5 and 0x6 return the primary, auxiliary and second-connector geographic address in bits 4:0, with bits 7:5 at 0. An input change becomes readable after the second rising edge and not after the first.
- R3: In the control byte, bit 7 (routing select), bits 6:4 (bus-mode outputs for lines 4, 3, 2) and bits 1:0 are writable. Bit 3 shows slot 2 bus-mode line 1 and bit 2 shows slot 1 bus-mode line 1, each through the two-flop synchronizer. Writes to bits 3:2 have no effect.
- R4: `term_en_a` follows control bit 0 and `term_en_b` follows control bit 1. A value of 1 inserts the series termination (clock slave) and 0 bypasses it (clock master). The two groups are independent.
- R5: After reset is released, the slot-ID byte reads 0x01 until the synchronizer has filled. On the third rising edge after release it loads bits 5:2 from primary geographic address bits 3:0, bit 1 with 0 and bit 0 with 1.
- R6: In the slot-ID byte (offset 0x8), bits 5:2 drive ID bits 4:1 of both slots. Bit 1 drives slot 2 ID bit 0 and bit 0 drives slot 1 ID bit 0. Bits 7:6 read 0.
- R7: With routing select 0, mezzanine 1 lines 0–15 are joined to switch lines 0–15, and mezzanine 2 lines 0–15 are joined to switch lines 16–31. Mezzanine lines 16–31 of both slots see only their own drive. Each joined line resolves to the AND of its pull inputs.
- R8: With routing select 1, line i of mezzanine 1, mezzanine 2 and the switch form one net, and all three see the AND of their three pulls.
- R9: Offset 0xE returns the logic revision parameter and offset 0xF returns the board revision parameter. Writes to them have no effect.
- R10: Only address bits 3:0 are decoded, so the window repeats every 16 bytes. Offsets 0x0–0x3 and 0x9–0xD read 0x00. Writes to any offset other than 0x7 and 0x8 leave all writable state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Local bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ga_pri | input | GA_W | Primary geographic address pins |
| ga_aux | input | GA_W | Auxiliary geographic address pins |
| ga_j4 | input | GA_W | Second-connector geographic address pins |
| bm1_slot1 | input | 1 | Slot 1 bus-mode line 1 |
| bm1_slot2 | input | 1 | Slot 2 bus-mode line 1 |
| bm_hi_o | output | 3 | Bus-mode lines 4, 3, 2 (bit 2 = line 4) |
| term_en_a | output | 1 | Clock/frame group A termination enable |
| term_en_b | output | 1 | Clock/frame group B termination enable |
| slot_id_1 | output | GA_W | Slot 1 ID |
| slot_id_2 | output | GA_W | Slot 2 ID |
| mez1_pull_n | input | LINES | Mezzanine 1 active-low line pulls |
| mez2_pull_n | input | LINES | Mezzanine 2 active-low line pulls |
| tsw_pull_n | input | LINES | Switch device active-low line pulls |
| mez1_line | output | LINES | Resolved lines seen by mezzanine 1 |
| mez2_line | output | LINES | Resolved lines seen by mezzanine 2 |
| tsw_line | output | LINES | Resolved lines seen by the switch device |

## Verification
The assertions assume that the geographic address pins stay static while the slot-ID default loads. They also assume that a write strobe lasts one clock and that address and data are steady around that edge. The bench meets both assumptions by changing pins and bus signals only on falling edges, and by changing the primary address only while reset is held. The router checks assume that every pull input is a defined 0 or 1. The bench drives all pull vectors to known patterns before it samples any line.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OFF_GA_PRI    = 4'h4;
  localparam logic [3:0] OFF_GA_AUX    = 4'h5;
  localparam logic [3:0] OFF_GA_J4     = 4'h6;
  localparam logic [3:0] OFF_CTRL      = 4'h7;
  localparam logic [3:0] OFF_SLOT      = 4'h8;
  localparam logic [3:0] OFF_REV_LOGIC = 4'hE;
  localparam logic [3:0] OFF_REV_BOARD = 4'hF;

  typedef struct packed {
    logic       route_all;
    logic [2:0] bm_hi;
    logic       term_b;
    logic       term_a;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{route_all: 1'b0, bm_hi: 3'b111, term_b: 1'b1, term_a: 1'b1};
endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ccr_regs.sv
module ccr_regs
  import ccr_pkg::*;
#(
  parameter int          GA_W        = 5,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  LOGIC_REV   = 8'h21,
  parameter logic [7:0]  BOARD_REV   = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        off,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [GA_W-1:0]   ga_pri_s,
  input  logic [GA_W-1:0]   ga_aux_s,
  input  logic [GA_W-1:0]   ga_j4_s,
  input  logic              bm1_s1_s,
  input  logic              bm1_s2_s,
  output ctrl_t             ctrl_o,
  output logic [GA_W-2:0]   slot_hi_o,
  output logic              slot_b0_1_o,
  output logic              slot_b0_2_o
);
  localparam int CNT_W   = $clog2(SYNC_STAGES + 1);
  localparam int GA_PAD  = BYTE_W - GA_W;
  localparam int SLT_PAD = BYTE_W - GA_W - 1;

  ctrl_t           ctrl_q, ctrl_d;
  logic [GA_W-2:0] slot_hi_q, slot_hi_d;
  logic            s1_q, s1_d, s2_q, s2_d;
  logic [CNT_W-1:0] cnt_q;
  logic            loaded_q;
  logic            warm, load_now, wr_ctrl, wr_slot;
  logic            ctrl_en, slot_en, cnt_en;

  assign warm     = (cnt_q == CNT_W'(SYNC_STAGES));
  assign load_now = warm && !loaded_q;
  assign wr_ctrl  = wr && (off == OFF_CTRL);
  assign wr_slot  = wr && (off == OFF_SLOT);
  assign ctrl_en  = wr_ctrl;
  assign slot_en  = load_now || wr_slot;
  assign cnt_en   = !warm;

  // next-state
  always_comb begin
    ctrl_d    = ctrl_q;
    slot_hi_d = slot_hi_q;
    s1_d      = s1_q;
    s2_d      = s2_q;
    if (wr_ctrl) begin
      ctrl_d.route_all = wdata[7];
      ctrl_d.bm_hi     = wdata[6:4];
      ctrl_d.term_b    = wdata[1];
      ctrl_d.term_a    = wdata[0];
    end
    if (load_now) begin
      slot_hi_d = ga_pri_s[GA_W-2:0];
      s2_d      = 1'b0;
      s1_d      = 1'b1;
    end else if (wr_slot) begin
      slot_hi_d = wdata[GA_W:2];
      s2_d      = wdata[1];
      s1_d      = wdata[0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      slot_hi_q <= '0;
      s2_q      <= 1'b0;
      s1_q      <= 1'b1;
      cnt_q     <= '0;
      loaded_q  <= 1'b0;
    end else begin
      if (ctrl_en)  ctrl_q <= ctrl_d;
      if (slot_en) begin
        slot_hi_q <= slot_hi_d;
        s2_q      <= s2_d;
        s1_q      <= s1_d;
      end
      if (cnt_en)   cnt_q <= cnt_q + 1'b1;
      if (load_now) loaded_q <= 1'b1;
    end
  end

  // read mux
  always_comb begin
    unique case (off)
      OFF_GA_PRI:    rdata = {{GA_PAD{1'b0}}, ga_pri_s};
      OFF_GA_AUX:    rdata = {{GA_PAD{1'b0}}, ga_aux_s};
      OFF_GA_J4:     rdata = {{GA_PAD{1'b0}}, ga_j4_s};
      OFF_CTRL:      rdata = {ctrl_q.route_all, ctrl_q.bm_hi, bm1_s2_s, bm1_s1_s,
                              ctrl_q.term_b, ctrl_q.term_a};
      OFF_SLOT:      rdata = {{SLT_PAD{1'b0}}, slot_hi_q, s2_q, s1_q};
      OFF_REV_LOGIC: rdata = LOGIC_REV;
      OFF_REV_BOARD: rdata = BOARD_REV;
      default:       rdata = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign slot_hi_o   = slot_hi_q;
  assign slot_b0_1_o = s1_q;
  assign slot_b0_2_o = s2_q;

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q.route_all == $past(wdata[7])) && (ctrl_q.bm_hi == $past(wdata[6:4]))); // R3
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off != OFF_CTRL && off != OFF_SLOT && loaded_q) |=>
      $stable(ctrl_q) && $stable(slot_hi_q) && $stable(s1_q) && $stable(s2_q)); // R10
  AST_SLOT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (slot_hi_q == $past(ga_pri_s[GA_W-2:0])) && s1_q && !s2_q); // R5
  AST_GA_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (off == OFF_GA_PRI || off == OFF_GA_AUX || off == OFF_GA_J4) |-> rdata[BYTE_W-1:GA_W] == '0); // R2
endmodule

// File: rtl/ccr_tdm_router.sv
module ccr_tdm_router #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             route_all,
  input  logic [LINES-1:0] mez1_pull_n,
  input  logic [LINES-1:0] mez2_pull_n,
  input  logic [LINES-1:0] tsw_pull_n,
  output logic [LINES-1:0] mez1_line,
  output logic [LINES-1:0] mez2_line,
  output logic [LINES-1:0] tsw_line
);
  localparam int HALF = LINES / 2;

  for (genvar g = 0; g < HALF; g++) begin : g_pair
    logic shared_lo, shared_hi, net_a, net_b;
    assign shared_lo = mez1_pull_n[g] & mez2_pull_n[g] & tsw_pull_n[g];
    assign shared_hi = mez1_pull_n[g+HALF] & mez2_pull_n[g+HALF] & tsw_pull_n[g+HALF];
    assign net_a     = mez1_pull_n[g] & tsw_pull_n[g];
    assign net_b     = mez2_pull_n[g] & tsw_pull_n[g+HALF];

    assign mez1_line[g]      = route_all ? shared_lo : net_a;
    assign tsw_line[g]       = route_all ? shared_lo : net_a;
    assign mez2_line[g]      = route_all ? shared_lo : net_b;
    assign tsw_line[g+HALF]  = route_all ? shared_hi : net_b;
    assign mez1_line[g+HALF] = route_all ? shared_hi : mez1_pull_n[g+HALF];
    assign mez2_line[g+HALF] = route_all ? shared_hi : mez2_pull_n[g+HALF];
  end

  AST_SHARED_ONE_NET: assert property (@(posedge clk) disable iff (!rst_n)
    route_all |-> (mez1_line == tsw_line) && (mez2_line == tsw_line)); // R8
  AST_LEGACY_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    !route_all |-> (mez1_line[HALF-1:0] == tsw_line[HALF-1:0]) &&
                   (mez2_line[HALF-1:0] == tsw_line[LINES-1:HALF])); // R7
  AST_WIRED_AND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mez1_line & ~mez1_pull_n) == '0) && ((mez2_line & ~mez2_pull_n) == '0) &&
    ((tsw_line & ~tsw_pull_n) == '0)); // R7
endmodule

// File: rtl/carrier_cfg_router.sv
module carrier_cfg_router
  import ccr_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         GA_W        = 5,
  parameter int         LINES       = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] LOGIC_REV   = 8'h21,
  parameter logic [7:0] BOARD_REV   = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [GA_W-1:0]   ga_pri,
  input  logic [GA_W-1:0]   ga_aux,
  input  logic [GA_W-1:0]   ga_j4,
  input  logic              bm1_slot1,
  input  logic              bm1_slot2,
  output logic [2:0]        bm_hi_o,
  output logic              term_en_a,
  output logic              term_en_b,
  output logic [GA_W-1:0]   slot_id_1,
  output logic [GA_W-1:0]   slot_id_2,
  input  logic [LINES-1:0]  mez1_pull_n,
  input  logic [LINES-1:0]  mez2_pull_n,
  input  logic [LINES-1:0]  tsw_pull_n,
  output logic [LINES-1:0]  mez1_line,
  output logic [LINES-1:0]  mez2_line,
  output logic [LINES-1:0]  tsw_line
);
  localparam int SYN_W = 3 * GA_W + 2;

  logic [SYN_W-1:0] syn_q;
  logic [GA_W-1:0]  ga_pri_s, ga_aux_s, ga_j4_s;
  logic             bm1_s1_s, bm1_s2_s;
  ctrl_t            ctrl;
  logic [GA_W-2:0]  slot_hi;
  logic             slot_b0_1, slot_b0_2;
  logic             unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[ADDR_W-1:4];

  ccr_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ga_pri, ga_aux, ga_j4, bm1_slot2, bm1_slot1}),
    .q     (syn_q)
  );

  assign {ga_pri_s, ga_aux_s, ga_j4_s, bm1_s2_s, bm1_s1_s} = syn_q;

  ccr_regs #(
    .GA_W(GA_W), .SYNC_STAGES(SYNC_STAGES), .LOGIC_REV(LOGIC_REV), .BOARD_REV(BOARD_REV)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .off         (bus_addr[3:0]),
    .wr          (bus_wr),
    .wdata       (bus_wdata),
    .rdata       (bus_rdata),
    .ga_pri_s    (ga_pri_s),
    .ga_aux_s    (ga_aux_s),
    .ga_j4_s     (ga_j4_s),
    .bm1_s1_s    (bm1_s1_s),
    .bm1_s2_s    (bm1_s2_s),
    .ctrl_o      (ctrl),
    .slot_hi_o   (slot_hi),
    .slot_b0_1_o (slot_b0_1),
    .slot_b0_2_o (slot_b0_2)
  );

  ccr_tdm_router #(.LINES(LINES)) u_router (
    .clk         (clk),
    .rst_n       (rst_n),
    .route_all   (ctrl.route_all),
    .mez1_pull_n (mez1_pull_n),
    .mez2_pull_n (mez2_pull_n),
    .tsw_pull_n  (tsw_pull_n),
    .mez1_line   (mez1_line),
    .mez2_line   (mez2_line),
    .tsw_line    (tsw_line)
  );

  assign bm_hi_o   = ctrl.bm_hi;
  assign term_en_a = ctrl.term_a;
  assign term_en_b = ctrl.term_b;
  assign slot_id_1 = {slot_hi, slot_b0_1};
  assign slot_id_2 = {slot_hi, slot_b0_2};

  AST_TERM_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:0] == OFF_CTRL) |=>
      (term_en_a == $past(bus_wdata[0])) && (term_en_b == $past(bus_wdata[1]))); // R4
  AST_SLOT_SHARED_HI: assert property (@(posedge clk) disable iff (!rst_n)
    slot_id_1[GA_W-1:1] == slot_id_2[GA_W-1:1]); // R6
endmodule

// File: tb/carrier_cfg_router_tb.sv
module carrier_cfg_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 32;
  localparam int HALF  = LINES / 2;
  localparam int NV    = 25;

  // {op(2: 0 read+check, 1 write), req(4), addr(8), wdata(8), expected(8)}
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 4'd2,  8'h04, 8'h00, 8'h1A},  // R2 primary GA
    {2'd0, 4'd2,  8'h05, 8'h00, 8'h05},  // R2 auxiliary GA
    {2'd0, 4'd2,  8'h06, 8'h00, 8'h13},  // R2 second connector GA
    {2'd0, 4'd10, 8'h14, 8'h00, 8'h1A},  // R10 mirror of 0x4
    {2'd0, 4'd9,  8'h0E, 8'h00, 8'h21},  // R9 logic revision
    {2'd0, 4'd9,  8'h0F, 8'h00, 8'h20},  // R9 board revision
    {2'd0, 4'd10, 8'h02, 8'h00, 8'h00},  // R10 unmapped
    {2'd0, 4'd10, 8'h0B, 8'h00, 8'h00},  // R10 unmapped
    {2'd1, 4'd3,  8'h07, 8'hFF, 8'h00},
    {2'd0, 4'd3,  8'h07, 8'h00, 8'hF3},  // R3 bits 3:2 follow pins
    {2'd1, 4'd3,  8'h07, 8'h0C, 8'h00},
    {2'd0, 4'd3,  8'h07, 8'h00, 8'h00},  // R3
    {2'd1, 4'd10, 8'h17, 8'h82, 8'h00},
    {2'd0, 4'd10, 8'h07, 8'h00, 8'h82},  // R10 write through mirror
    {2'd1, 4'd6,  8'h08, 8'hFF, 8'h00},
    {2'd0, 4'd6,  8'h08, 8'h00, 8'h3F},  // R6 bits 7:6 read 0
    {2'd1, 4'd6,  8'h08, 8'h16, 8'h00},
    {2'd0, 4'd6,  8'h08, 8'h00, 8'h16},  // R6
    {2'd1, 4'd10, 8'h04, 8'hFF, 8'h00},
    {2'd0, 4'd10, 8'h04, 8'h00, 8'h1A},  // R10 read-only ignored
    {2'd1, 4'd9,  8'h0E, 8'h00, 8'h00},
    {2'd0, 4'd9,  8'h0E, 8'h00, 8'h21},  // R9 write ignored
    {2'd1, 4'd10, 8'h03, 8'hFF, 8'h00},
    {2'd0, 4'd10, 8'h07, 8'h00, 8'h82},  // R10
    {2'd0, 4'd10, 8'h08, 8'h00, 8'h16}   // R10
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       bus_addr, bus_wdata, bus_rdata;
  logic             bus_wr;
  logic [4:0]       ga_pri, ga_aux, ga_j4, slot_id_1, slot_id_2;
  logic             bm1_slot1, bm1_slot2, term_en_a, term_en_b;
  logic [2:0]       bm_hi_o;
  logic [LINES-1:0] mez1_pull_n, mez2_pull_n, tsw_pull_n;
  logic [LINES-1:0] mez1_line, mez2_line, tsw_line;

  int  n_vec  = 0;
  int  n_miss = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_cfg_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ga_pri(ga_pri), .ga_aux(ga_aux),
    .ga_j4(ga_j4), .bm1_slot1(bm1_slot1), .bm1_slot2(bm1_slot2), .bm_hi_o(bm_hi_o),
    .term_en_a(term_en_a), .term_en_b(term_en_b), .slot_id_1(slot_id_1),
    .slot_id_2(slot_id_2), .mez1_pull_n(mez1_pull_n), .mez2_pull_n(mez2_pull_n),
    .tsw_pull_n(tsw_pull_n), .mez1_line(mez1_line), .mez2_line(mez2_line),
    .tsw_line(tsw_line)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    chk(tag, {88'd0, bus_rdata}, {88'd0, exp});
  endtask

  // Expected line values from R7 / R8
  function automatic logic [3*LINES-1:0] route_model(input logic all,
      input logic [LINES-1:0] m1, input logic [LINES-1:0] m2, input logic [LINES-1:0] t);
    logic [LINES-1:0] e1, e2, et;
    for (int i = 0; i < LINES; i++) begin
      if (all) begin
        e1[i] = m1[i] & m2[i] & t[i]; e2[i] = e1[i]; et[i] = e1[i];
      end
    end
    if (!all) begin
      for (int i = 0; i < HALF; i++) begin
        e1[i] = m1[i] & t[i];       et[i] = e1[i];
        e2[i] = m2[i] & t[i+HALF];  et[i+HALF] = e2[i];
        e1[i+HALF] = m1[i+HALF];    e2[i+HALF] = m2[i+HALF];
      end
    end
    return {e1, e2, et};
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_vec++; n_miss++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h07; bus_wr = 1'b0; bus_wdata = 8'h00;
    ga_pri = 5'h1A; ga_aux = 5'h05; ga_j4 = 5'h13; bm1_slot1 = 1'b0; bm1_slot2 = 1'b0;
    mez1_pull_n = '1; mez2_pull_n = '1; tsw_pull_n = '1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 ctrl byte in reset", {88'd0, bus_rdata}, {88'd0, 8'h73});
    chk("R1 outputs in reset", {91'd0, bm_hi_o, term_en_b, term_en_a}, {91'd0, 3'b111, 1'b1, 1'b1});
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read_chk("R5 slot default", 8'h08, 8'h29);
    #1;
    chk("R5 slot ports", {86'd0, slot_id_1, slot_id_2}, {86'd0, 5'h15, 5'h14});

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][29:28] == 2'd1) begin
        bus_write(VEC[v][23:16], VEC[v][15:8]);
      end else begin
        @(negedge clk);
        bus_addr = VEC[v][23:16]; bus_wr = 1'b0;
        #1;
        n_vec++;
        if (bus_rdata !== VEC[v][7:0]) begin
          n_miss++;
          $display("FAIL vector %0d R%0d addr=%0h actual=%0h expected=%0h",
                   v, VEC[v][27:24], VEC[v][23:16], bus_rdata, VEC[v][7:0]);
        end
      end
    end

    // R6 slot outputs after write of 0x16
    #1;
    chk("R6 slot ports", {86'd0, slot_id_1, slot_id_2}, {86'd0, 5'h0A, 5'h0B});

    // R4 termination groups independent
    bus_write(8'h07, 8'h01); #1;
    chk("R4 a=1 b=0", {94'd0, term_en_b, term_en_a}, {94'd0, 2'b01});
    bus_write(8'h07, 8'h02); #1;
    chk("R4 a=0 b=1", {94'd0, term_en_b, term_en_a}, {94'd0, 2'b10});
    // R3 bus-mode outputs
    bus_write(8'h07, 8'h50); #1;
    chk("R3 bus-mode outputs", {93'd0, bm_hi_o}, {93'd0, 3'b101});

    // R3 synchronizer latency for bus-mode line 1 of slot 2
    @(negedge clk); bm1_slot2 = 1'b1; bus_addr = 8'h07; #1;
    chk("R3 bm1 before edge", {88'd0, bus_rdata}, {88'd0, 8'h50});
    @(negedge clk); #1;
    chk("R3 bm1 after one edge", {88'd0, bus_rdata}, {88'd0, 8'h50});
    @(negedge clk); #1;
    chk("R3 bm1 after two edges", {88'd0, bus_rdata}, {88'd0, 8'h58});

    // R2 synchronizer latency for auxiliary address
    @(negedge clk); ga_aux = 5'h0A; bus_addr = 8'h05; #1;
    @(negedge clk); #1;
    chk("R2 aux after one edge", {88'd0, bus_rdata}, {88'd0, 8'h05});
    @(negedge clk); #1;
    chk("R2 aux after two edges", {88'd0, bus_rdata}, {88'd0, 8'h0A});

    // R7 legacy then R8 shared routing
    bus_write(8'h07, 8'h03);
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      mez1_pull_n = ~(32'h1 << ((p * 7) % 32));
      mez2_pull_n = ~(32'h1 << ((p * 5 + 3) % 32)) & ~(32'h1 << p);
      tsw_pull_n  = ~(32'h1 << ((p * 11 + 20) % 32));
      #1;
      chk("R7 legacy routing", {mez1_line, mez2_line, tsw_line},
          route_model(1'b0, mez1_pull_n, mez2_pull_n, tsw_pull_n));
    end
    bus_write(8'h07, 8'h83);
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      mez1_pull_n = ~(32'h1 << ((p * 9 + 1) % 32));
      mez2_pull_n = ~(32'h1 << ((p * 3 + 17) % 32));
      tsw_pull_n  = ~(32'h1 << ((p * 13 + 6) % 32));
      #1;
      chk("R8 shared routing", {mez1_line, mez2_line, tsw_line},
          route_model(1'b1, mez1_pull_n, mez2_pull_n, tsw_pull_n));
    end

    // R5 second reset with a new primary address
    @(negedge clk); rst_n = 1'b0; ga_pri = 5'h07; bus_addr = 8'h08;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk("R5 slot before load", {88'd0, bus_rdata}, {88'd0, 8'h01});
    @(negedge clk); #1;
    chk("R5 slot after load", {88'd0, bus_rdata}, {88'd0, 8'h1D});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule